// File: doc/BRIEF.md
# Oscillator frequency calibration counter

This block measures how fast a slow or uncalibrated oscillator runs by counting cycles of a fast, trusted reference clock over a window of known length. The window is defined in cycles of the clock under test. Software selects one of four on-chip oscillators, or an external window input, as the window clock. It loads the window length, then sets a start bit. When the measurement completes, the start bit clears by itself and a 32-bit count of reference cycles can be read.

The block spans three clock domains: the bus clock, the window clock and the reference clock. A down counter in the window domain frames the window. A counter in the reference domain counts while a synchronised copy of the window flag is high. A return-to-zero handshake brings completion back to the bus domain, and the bus side captures the count only after the reference counter has stopped.

Top module: `cal_freq_meter`

## Requirements
- R1: Registers sit at byte offsets 0 (control), 2 (window length), 4 (result bits 15:0) and 6 (result bits 31:16), with bus_addr[0] required to be 0. All four registers read 0 after reset.
- R2: Control bits [1:0] pick the window clock from osc_clk[0..3] when control bit 3 is 0, and read back as written.
- R3: Writing control with bit 2 set starts a calibration. Bit 2 reads 1 from the next cycle until the result has been captured and the handshake has returned to idle, then reads 0.
- R4: With control bit 3 at 1, the window is counted on ext_win_in instead of an oscillator, and bit 3 reads back 1.
- R5: The window lasts N cycles of the window clock, where N is the window length register. A value of 0 is treated as 1.
- R6: The result equals the number of ref_clk cycles in the window, within ±1 of N·T_window/T_ref, and holds unchanged while no calibration is running.
- R7: The 32-bit result is split across offsets 4 (low half) and 6 (high half). Writes to either result offset have no effect.
- R8: While a calibration is running, writes to the control and window length registers are ignored, including a further start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Fast reference clock being counted |
| osc_clk | input | 4 | Oscillators under test, indexed by control [1:0] |
| ext_win_in | input | 1 | External window clock used when control bit 3 is 1 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when bus_en is low |

## Verification
Each oscillator is exercised with the same short window length. Their periods differ, so a wrong select shows up as a wrong ratio. The external source is run with oscillator select 0, which separates the window-source bit from the oscillator select. Window lengths of 0 and 1 check the minimum window. A window of several thousand cycles pushes the count past 16 bits and exercises the high result half. Writes made mid-run have to leave the result at the original configuration's value. Random runs mix sources and lengths against the expected product of length and period ratio.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DATA_W = 16;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LEN  = 2'd1,
    REG_RLO  = 2'd2,
    REG_RHI  = 2'd3
  } cal_reg_e;
endpackage

// File: rtl/cal_sync2.sv
module cal_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q    <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_n_o <= s1_q;
    end
  end
endmodule

// File: rtl/cal_window.sv
module cal_window #(
  parameter int LEN_W = 16
) (
  input  logic             win_clk,
  input  logic             rst_n,
  input  logic             req_a,
  input  logic [LEN_W-1:0] len,
  output logic             win_act,
  output logic             win_done
);
  logic             req_s;
  logic             act_d, done_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  cal_sync2 #(.W(1)) u_req_sync (.clk(win_clk), .rst_n(rst_n), .d(req_a), .q(req_s));

  always_comb begin
    act_d  = win_act;
    done_d = win_done;
    cnt_d  = cnt_q;
    if (!req_s) begin
      done_d = 1'b0;
    end else if (win_act) begin
      if (cnt_q <= LEN_W'(1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - LEN_W'(1);
      end
    end else if (!win_done) begin
      act_d = 1'b1;
      cnt_d = (len == '0) ? LEN_W'(1) : len;
    end
  end

  always_ff @(posedge win_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_act  <= 1'b0;
      win_done <= 1'b0;
      cnt_q    <= '0;
    end else begin
      win_act  <= act_d;
      win_done <= done_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/cal_refcnt.sv
module cal_refcnt #(
  parameter int RES_W = 32
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             act_a,
  input  logic             done_a,
  output logic [RES_W-1:0] cnt,
  output logic             fin
);
  logic             act_s, done_s, act_p;
  logic [RES_W-1:0] cnt_d;
  logic             fin_d;

  cal_sync2 #(.W(2)) u_sync (.clk(ref_clk), .rst_n(rst_n),
                             .d({act_a, done_a}), .q({act_s, done_s}));

  always_comb begin
    cnt_d = cnt;
    if (act_s && !act_p)
      cnt_d = RES_W'(1);
    else if (act_s)
      cnt_d = cnt + RES_W'(1);
    fin_d = done_s && !act_s;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_p <= 1'b0;
      cnt   <= '0;
      fin   <= 1'b0;
    end else begin
      act_p <= act_s;
      cnt   <= cnt_d;
      fin   <= fin_d;
    end
  end
endmodule

// File: rtl/cal_freq_meter.sv
module cal_freq_meter
  import cal_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int LEN_W = 16,
  parameter int RES_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [NSRC-1:0]   osc_clk,
  input  logic              ext_win_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic bus_rst_n, ref_rst_n, win_rst_n, win_clk;
  logic [SEL_W-1:0] cfg_sel_q, cfg_sel_d;
  logic             cfg_ext_q, cfg_ext_d;
  logic [LEN_W-1:0] cfg_len_q, cfg_len_d;
  logic             req_q, req_d, fin_p, fin_b, busy;
  logic [RES_W-1:0] res_q, res_d, ref_cnt;
  logic             win_act, win_done, ref_fin;
  logic             hit, wr_ctrl, wr_len, fin_rise;
  cal_reg_e         reg_idx;

  assign win_clk = cfg_ext_q ? ext_win_in : osc_clk[cfg_sel_q];

  cal_rst_sync u_rs_bus (.clk(clk),     .arst_n(rst_n), .rst_n_o(bus_rst_n));
  cal_rst_sync u_rs_ref (.clk(ref_clk), .arst_n(rst_n), .rst_n_o(ref_rst_n));
  cal_rst_sync u_rs_win (.clk(win_clk), .arst_n(rst_n), .rst_n_o(win_rst_n));

  cal_window #(.LEN_W(LEN_W)) u_win (
    .win_clk(win_clk), .rst_n(win_rst_n), .req_a(req_q), .len(cfg_len_q),
    .win_act(win_act), .win_done(win_done));

  cal_refcnt #(.RES_W(RES_W)) u_ref (
    .ref_clk(ref_clk), .rst_n(ref_rst_n), .act_a(win_act), .done_a(win_done),
    .cnt(ref_cnt), .fin(ref_fin));

  cal_sync2 #(.W(1)) u_fin_sync (.clk(clk), .rst_n(bus_rst_n), .d(ref_fin), .q(fin_b));

  assign busy     = req_q | fin_b;
  assign reg_idx  = cal_reg_e'(bus_addr[2:1]);
  assign hit      = bus_en && (bus_addr[0] == 1'b0);
  assign wr_ctrl  = hit && bus_we && (reg_idx == REG_CTRL) && !busy;
  assign wr_len   = hit && bus_we && (reg_idx == REG_LEN) && !busy;
  assign fin_rise = fin_b && !fin_p;

  always_comb begin
    cfg_sel_d = cfg_sel_q;
    cfg_ext_d = cfg_ext_q;
    cfg_len_d = cfg_len_q;
    req_d     = req_q;
    res_d     = res_q;
    if (wr_ctrl) begin
      cfg_sel_d = bus_wdata[SEL_W-1:0];
      cfg_ext_d = bus_wdata[3];
      req_d     = bus_wdata[2];
    end
    if (wr_len)
      cfg_len_d = bus_wdata[LEN_W-1:0];
    if (fin_rise) begin
      res_d = ref_cnt;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      cfg_sel_q <= '0;
      cfg_ext_q <= 1'b0;
      cfg_len_q <= '0;
      req_q     <= 1'b0;
      res_q     <= '0;
      fin_p     <= 1'b0;
    end else begin
      cfg_sel_q <= cfg_sel_d;
      cfg_ext_q <= cfg_ext_d;
      cfg_len_q <= cfg_len_d;
      req_q     <= req_d;
      res_q     <= res_d;
      fin_p     <= fin_b;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (reg_idx)
        REG_CTRL: begin
          bus_rdata[SEL_W-1:0] = cfg_sel_q;
          bus_rdata[2]         = busy;
          bus_rdata[3]         = cfg_ext_q;
        end
        REG_LEN:  bus_rdata = DATA_W'(cfg_len_q);
        REG_RLO:  bus_rdata = res_q[DATA_W-1:0];
        REG_RHI:  bus_rdata = DATA_W'(res_q >> DATA_W);
      endcase
    end
  end
endmodule

// File: rtl/cal_freq_meter_chk.sv
module cal_freq_meter_chk #(
  parameter int SEL_W = 2,
  parameter int LEN_W = 16,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic             req,
  input logic             fin,
  input logic             busy,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             cfg_ext,
  input logic [LEN_W-1:0] cfg_len,
  input logic [RES_W-1:0] res
);
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_sel) && $stable(cfg_ext) && $stable(cfg_len)));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res));

  assert_start_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(bus_en && bus_we && bus_addr == 3'd0 && bus_wdata[2]));

  assert_done_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> req);
endmodule

bind cal_freq_meter cal_freq_meter_chk #(.SEL_W(SEL_W), .LEN_W(LEN_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(bus_rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .req(req_q), .fin(fin_b),
  .busy(busy), .cfg_sel(cfg_sel_q), .cfg_ext(cfg_ext_q), .cfg_len(cfg_len_q),
  .res(res_q));

// File: tb/tb_cal_freq_meter.sv
`timescale 1ns/1ps
module tb_cal_freq_meter;
  localparam int TREF = 4;
  localparam int TEXT = 52;

  logic        clk, rst_n, ref_clk, ext_win_in;
  logic [3:0]  osc_clk;
  logic        bus_en, bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  int          n_chk, n_bad;
  logic        ended;

  cal_freq_meter dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk(osc_clk),
    .ext_win_in(ext_win_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial begin clk = 0; #0.25; forever #5 clk = ~clk; end
  initial begin ref_clk = 0; #0.5; forever #(TREF/2.0) ref_clk = ~ref_clk; end
  initial begin osc_clk[0] = 0; #1; forever #20 osc_clk[0] = ~osc_clk[0]; end
  initial begin osc_clk[1] = 0; #1; forever #6  osc_clk[1] = ~osc_clk[1]; end
  initial begin osc_clk[2] = 0; #1; forever #32 osc_clk[2] = ~osc_clk[2]; end
  initial begin osc_clk[3] = 0; #1; forever #14 osc_clk[3] = ~osc_clk[3]; end
  initial begin ext_win_in = 0; #1; forever #(TEXT/2) ext_win_in = ~ext_win_in; end

  function automatic int win_period(input int sel, input bit ext);
    if (ext) return TEXT;
    case (sel)
      0: return 40;
      1: return 12;
      2: return 64;
      default: return 28;
    endcase
  endfunction

  function automatic longint expect_count(input int sel, input bit ext, input int len);
    int n;
    n = (len == 0) ? 1 : len;
    return longint'(n) * win_period(sel, ext) / TREF;
  endfunction

  task automatic check(input string req, input longint got, input longint exp, input int tol);
    n_chk++;
    if (got > exp + tol || got < exp - tol) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (tol %0d)", req, got, exp, tol);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 60000; i++) begin
      rd(3'd0, v);
      if (!v[2]) return;
    end
  endtask

  task automatic read_result(output longint r);
    logic [15:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd6, hi);
    r = {hi, lo};
  endtask

  task automatic run_cal(input int sel, input bit ext, input int len, input string req);
    logic [15:0] v;
    longint r;
    wr(3'd2, 16'(len));
    wr(3'd0, {12'd0, ext, 1'b1, 2'(sel)});
    rd(3'd0, v);
    check("R3 start bit set while running", longint'(v[2]), 1, 0);
    wait_idle();
    read_result(r);
    check(req, r, expect_count(sel, ext, len), 1);
  endtask

  initial begin
    int unsigned seed_init;
    logic [15:0] v;
    longint r;
    n_chk = 0; n_bad = 0; ended = 0;
    seed_init = $urandom(32'd20240611);
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(3'(2 * a), v);
      check("R1 reset value", longint'(v), 0, 0);
    end

    wr(3'd2, 16'h00AB);
    rd(3'd2, v);
    check("R1 window length readback", longint'(v), 16'h00AB, 0);
    wr(3'd0, 16'h0002);
    rd(3'd0, v);
    check("R2 select readback", longint'(v), 16'h0002, 0);
    wr(3'd0, 16'h0008);
    rd(3'd0, v);
    check("R4 window source bit readback", longint'(v), 16'h0008, 0);

    wr(3'd4, 16'h1234);
    wr(3'd6, 16'h5678);
    read_result(r);
    check("R7 result offsets read-only", r, 0, 0);

    for (int s = 0; s < 4; s++)
      run_cal(s, 1'b0, 6, "R2 per-oscillator ratio");

    run_cal(1, 1'b0, 0, "R5 zero length treated as one");
    run_cal(3, 1'b0, 1, "R5 single cycle window");
    run_cal(0, 1'b1, 9, "R4 external window source");

    // R8: reconfiguration attempts during a run are ignored
    wr(3'd2, 16'd20);
    wr(3'd0, 16'h0004);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h000D);
    wait_idle();
    rd(3'd2, v);
    check("R8 length unchanged by busy write", longint'(v), 20, 0);
    rd(3'd0, v);
    check("R8 control unchanged by busy write", longint'(v), 0, 0);
    read_result(r);
    check("R8 result from original configuration", r, expect_count(0, 1'b0, 20), 1);
    rd(3'd0, v);
    check("R3 start bit clear after completion", longint'(v[2]), 0, 0);
    read_result(r);
    check("R6 result holds while idle", r, expect_count(0, 1'b0, 20), 1);

    run_cal(2, 1'b0, 5000, "R7 count above 16 bits");
    rd(3'd6, v);
    check("R7 high half", longint'(v), (expect_count(2, 1'b0, 5000) >> 16), 0);

    for (int k = 0; k < 8; k++) begin
      int s, n;
      bit e;
      s = int'($urandom_range(3, 0));
      e = ($urandom_range(3, 0) == 0);
      n = int'($urandom_range(60, 1));
      run_cal(s, e, n, "R6 random run");
    end

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule